// File: doc/BRIEF.md
# PS/2 Controller Host Command Sequencer

This block masters the two byte-wide registers of an 8042-style keyboard and pointing-device controller on behalf of a simpler user. A user request names one of four operations and, for byte sends, the byte itself. The sequencer then runs the whole register dialogue without further help. Every register write it issues waits for the controller's input buffer to drain. It does this by reading the status register once per cycle until the input-full flag reads clear.

Bring-up shuts off both channels, drains any stale bytes, and then turns on both channel interrupts with scancode translation. Shut-down clears both interrupt enables and keeps translation on. A keyboard byte goes straight to the data register. A pointing-device byte is preceded by a routing command written to the command register. Every wait loop is bounded by a cycle limit. When a loop runs out, the operation is abandoned and a sticky error flag is raised.

The request side is a valid/ready channel. `req_ready` is high only while the sequencer is idle, and it does not depend combinationally on `req_valid`. `req_op` and `req_byte` are sampled on the cycle in which both `req_valid` and `req_ready` are high. A producer may hold `req_valid` high for as long as it likes. While an operation runs, the request is simply left waiting.

Top module: `ps2_host_seq`

## Requirements
- R1: After reset `busy`, `done` and `tmo_err` are low, `req_ready` is high, and neither `bus_rd` nor `bus_wr` is asserted.
- R2: A request is taken only in a cycle with `req_valid` and `req_ready` both high. `req_ready` is low for the whole of an operation, so a request offered during that time has no effect on the register traffic.
- R3: Every register write is immediately preceded, in the previous cycle, by a status read (`bus_addr`=1) that returned bit 1 (input full, 0x02) clear. While bit 1 reads set, the status read repeats every cycle.
- R4: Operation code 0 (bring-up) writes, in order: 0x60 to the command register, 0x30 to the data register, a drain, 0x60 to the command register, and 0x43 to the data register.
- R5: A drain reads status. When bit 0 (output full, 0x01) is set, it reads the data register (`bus_addr`=0) in the next cycle and returns to the status read. It ends on a status read with bit 0 clear.
- R6: Operation code 1 (shut-down) writes 0x60 to the command register and then 0x40 to the data register.
- R7: Operation code 2 writes the request byte to the data register and makes no other write.
- R8: Operation code 3 writes 0xD4 to the command register and then the request byte to the data register.
- R9: `busy` is high from the cycle after acceptance through the cycle of the last register access. `done` is high for exactly one cycle, the next one, with `busy` low.
- R10: If input full reads set on TMO_POLLS consecutive polls, the operation is abandoned without that write. `done` pulses, and `tmo_err` rises and stays high until reset.
- R11: If one drain reads the data register TMO_POLLS times, the operation is abandoned in the same way, with `tmo_err` raised.
- R12: Operation codes are 0 bring-up, 1 shut-down, 2 keyboard byte, 3 pointing-device byte.
- R13: `bus_rd` and `bus_wr` are never high together, and neither is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | Operation code (R12) |
| req_byte | input | 8 | Byte to send for operation codes 2 and 3 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| tmo_err | output | 1 | Sticky wait-loop timeout flag |
| bus_addr | output | 1 | Register select: 0 data, 1 status/command |
| bus_rd | output | 1 | Register read strobe |
| bus_wr | output | 1 | Register write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the same cycle as `bus_rd` |

## Verification
The assertions assume that the controller answers a read within the same cycle, and that `bus_rdata` is stable through any cycle that has `bus_rd` high. The checks on polling and on drain order are based on this. In the bench, `bus_rdata` is driven by a behavioural controller model. That model updates its state only at clock edges and serves reads combinationally from that state, so this assumption always holds. The bench model can make input full stay set for a chosen number of polls or for ever, and it can preload stale output bytes. This lets it reach both timeout paths and the normal drain path without ever presenting a read value that changes within a cycle.

// File: rtl/ps2seq_pkg.sv
package ps2seq_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PC_W   = 3;

  // status register bit positions decoded by the sequencer
  localparam int unsigned STAT_OFULL = 0;
  localparam int unsigned STAT_IFULL = 1;

  // controller commands
  localparam logic [BYTE_W-1:0] CMD_SET_CFG = 8'h60;
  localparam logic [BYTE_W-1:0] CMD_TO_AUX  = 8'hD4;

  // configuration byte fields
  localparam logic [BYTE_W-1:0] CFG_KBD_IRQ = 8'h01;
  localparam logic [BYTE_W-1:0] CFG_AUX_IRQ = 8'h02;
  localparam logic [BYTE_W-1:0] CFG_KBD_OFF = 8'h10;
  localparam logic [BYTE_W-1:0] CFG_AUX_OFF = 8'h20;
  localparam logic [BYTE_W-1:0] CFG_XLATE   = 8'h40;

  localparam logic [BYTE_W-1:0] CFG_SHUT  = CFG_KBD_OFF | CFG_AUX_OFF;
  localparam logic [BYTE_W-1:0] CFG_RUN   = CFG_KBD_IRQ | CFG_AUX_IRQ | CFG_XLATE;
  localparam logic [BYTE_W-1:0] CFG_QUIET = CFG_XLATE;

  typedef enum logic [1:0] {
    OP_INIT    = 2'd0,
    OP_QUIESCE = 2'd1,
    OP_KBD     = 2'd2,
    OP_AUX     = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    K_CMD   = 2'd0,
    K_DAT   = 2'd1,
    K_FLUSH = 2'd2,
    K_END   = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [BYTE_W-1:0] val;
  } step_t;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_POLL  = 3'd1,
    S_WRITE = 3'd2,
    S_FSTAT = 3'd3,
    S_FDATA = 3'd4
  } st_e;

endpackage

// File: rtl/ps2seq_prog.sv
module ps2seq_prog
  import ps2seq_pkg::*;
(
  input  op_e               op,
  input  logic [PC_W-1:0]   pc,
  input  logic [BYTE_W-1:0] ubyte,
  output step_t             step
);

  always_comb begin
    step = '{kind: K_END, val: '0};
    unique case (op)
      OP_INIT: begin
        unique case (pc)
          3'd0:    step = '{kind: K_CMD,   val: CMD_SET_CFG};
          3'd1:    step = '{kind: K_DAT,   val: CFG_SHUT};
          3'd2:    step = '{kind: K_FLUSH, val: '0};
          3'd3:    step = '{kind: K_CMD,   val: CMD_SET_CFG};
          3'd4:    step = '{kind: K_DAT,   val: CFG_RUN};
          default: step = '{kind: K_END,   val: '0};
        endcase
      end
      OP_QUIESCE: begin
        unique case (pc)
          3'd0:    step = '{kind: K_CMD, val: CMD_SET_CFG};
          3'd1:    step = '{kind: K_DAT, val: CFG_QUIET};
          default: step = '{kind: K_END, val: '0};
        endcase
      end
      OP_KBD: begin
        if (pc == 3'd0) step = '{kind: K_DAT, val: ubyte};
        else            step = '{kind: K_END, val: '0};
      end
      OP_AUX: begin
        unique case (pc)
          3'd0:    step = '{kind: K_CMD, val: CMD_TO_AUX};
          3'd1:    step = '{kind: K_DAT, val: ubyte};
          default: step = '{kind: K_END, val: '0};
        endcase
      end
      default: step = '{kind: K_END, val: '0};
    endcase
  end

endmodule

// File: rtl/ps2seq_wdog.sv
module ps2seq_wdog #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic hit
);

  localparam int unsigned CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  assign hit = tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/ps2seq_bus.sv
module ps2seq_bus
  import ps2seq_pkg::*;
(
  input  st_e               state,
  input  step_t             step,
  output logic              bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [BYTE_W-1:0] bus_wdata
);

  always_comb begin
    bus_addr  = 1'b0;
    bus_rd    = 1'b0;
    bus_wr    = 1'b0;
    bus_wdata = '0;
    unique case (state)
      S_POLL, S_FSTAT: begin
        bus_rd   = 1'b1;
        bus_addr = 1'b1;
      end
      S_FDATA: bus_rd = 1'b1;
      S_WRITE: begin
        bus_wr    = 1'b1;
        bus_addr  = (step.kind == K_CMD);
        bus_wdata = step.val;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ps2seq_core.sv
module ps2seq_core
  import ps2seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [BYTE_W-1:0] req_byte,
  input  logic              stat_ifull,
  input  logic              stat_ofull,
  input  step_t             step_nxt,
  input  logic              wd_hit,
  output st_e               state,
  output logic [PC_W-1:0]   pc,
  output op_e               op_q,
  output logic [BYTE_W-1:0] byte_q,
  output logic              busy,
  output logic              done,
  output logic              tmo_err,
  output logic              wd_clr,
  output logic              wd_tick
);

  logic accept;
  logic advance;

  assign busy    = (state != S_IDLE);
  assign accept  = req_valid && !busy;
  assign advance = (state == S_WRITE) || (state == S_FSTAT && !stat_ofull);
  assign wd_tick = (state == S_POLL && stat_ifull) || (state == S_FDATA);
  assign wd_clr  = !busy || advance;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pc      <= '0;
      op_q    <= OP_INIT;
      byte_q  <= '0;
      done    <= 1'b0;
      tmo_err <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            state  <= S_POLL;
            pc     <= '0;
            op_q   <= op_e'(req_op);
            byte_q <= req_byte;
          end
        end
        S_POLL: begin
          if (!stat_ifull) begin
            state <= S_WRITE;
          end else if (wd_hit) begin
            state   <= S_IDLE;
            done    <= 1'b1;
            tmo_err <= 1'b1;
          end
        end
        S_FSTAT: begin
          if (stat_ofull) state <= S_FDATA;
        end
        S_FDATA: begin
          if (wd_hit) begin
            state   <= S_IDLE;
            done    <= 1'b1;
            tmo_err <= 1'b1;
          end else begin
            state <= S_FSTAT;
          end
        end
        default: ;
      endcase
      if (advance) begin
        pc <= pc + 1'b1;
        unique case (step_nxt.kind)
          K_END: begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
          K_FLUSH: state <= S_FSTAT;
          default: state <= S_POLL;
        endcase
      end
    end
  end

endmodule

// File: rtl/ps2_host_seq.sv
module ps2_host_seq
  import ps2seq_pkg::*;
#(
  parameter int unsigned TMO_POLLS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [BYTE_W-1:0] req_byte,
  output logic              busy,
  output logic              done,
  output logic              tmo_err,
  output logic              bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [BYTE_W-1:0] bus_wdata,
  input  logic [BYTE_W-1:0] bus_rdata
);

  localparam int unsigned LOOKAHEAD = 2;

  st_e               state;
  logic [PC_W-1:0]   pc;
  op_e               op_q;
  logic [BYTE_W-1:0] byte_q;
  logic              wd_clr;
  logic              wd_tick;
  logic              wd_hit;
  step_t             steps [LOOKAHEAD];

  logic unused_rdata;
  assign unused_rdata = ^bus_rdata[BYTE_W-1:2];

  // current step and the one after it
  for (genvar g = 0; g < LOOKAHEAD; g++) begin : g_prog
    ps2seq_prog u_prog (
      .op    (op_q),
      .pc    (pc + PC_W'(g)),
      .ubyte (byte_q),
      .step  (steps[g])
    );
  end

  ps2seq_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_byte   (req_byte),
    .stat_ifull (bus_rdata[STAT_IFULL]),
    .stat_ofull (bus_rdata[STAT_OFULL]),
    .step_nxt   (steps[1]),
    .wd_hit     (wd_hit),
    .state      (state),
    .pc         (pc),
    .op_q       (op_q),
    .byte_q     (byte_q),
    .busy       (busy),
    .done       (done),
    .tmo_err    (tmo_err),
    .wd_clr     (wd_clr),
    .wd_tick    (wd_tick)
  );

  ps2seq_wdog #(.LIMIT(TMO_POLLS)) u_wdog (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (wd_clr),
    .tick  (wd_tick),
    .hit   (wd_hit)
  );

  ps2seq_bus u_bus (
    .state     (state),
    .step      (steps[0]),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata)
  );

  assign req_ready = !busy;

endmodule

// File: rtl/ps2_host_seq_chk.sv
module ps2_host_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic tmo_err,
  input logic bus_addr,
  input logic bus_rd,
  input logic bus_wr,
  input logic stat_ifull,
  input logic stat_ofull
);

  // R13
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd, bus_wr}));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_rd && !bus_wr);

  // R2
  take_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  // R3
  poll_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> $past(bus_rd && bus_addr && !stat_ifull));

  // R5
  drain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_addr) |-> $past(bus_rd && bus_addr && stat_ofull));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |=> tmo_err);

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_err) |-> done);

endmodule

bind ps2_host_seq ps2_host_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .busy       (busy),
  .done       (done),
  .tmo_err    (tmo_err),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .stat_ifull (bus_rdata[1]),
  .stat_ofull (bus_rdata[0])
);

// File: tb/ps2_host_seq_tb.sv
module ps2_host_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [7:0] req_byte = 8'h00;
  logic       req_ready, busy, done, tmo_err;
  logic       bus_addr, bus_rd, bus_wr;
  logic [7:0] bus_wdata, bus_rdata;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_host_seq #(.TMO_POLLS(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_byte(req_byte), .busy(busy), .done(done),
    .tmo_err(tmo_err), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // ---------------- controller model ----------------
  int         bsy_left;
  bit         stuck = 1'b0;
  int         cfg_bsy = 0;
  logic [7:0] ob_mem [64];
  int         ob_rd;
  int         ob_wr = 0;
  logic [7:0] wl_addr [256];
  logic [7:0] wl_data [256];
  int         wl_n = 0;
  logic [7:0] stat;

  always_comb begin
    stat = 8'h00;
    stat[0] = (ob_rd < ob_wr);
    stat[1] = stuck || (bsy_left > 0);
    stat[5] = (ob_rd < ob_wr) ? ob_mem[ob_rd][0] : 1'b0;
    if (bus_addr)            bus_rdata = stat;
    else if (ob_rd < ob_wr)  bus_rdata = ob_mem[ob_rd];
    else                     bus_rdata = 8'hEE;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsy_left <= 0;
      ob_rd    <= 0;
    end else begin
      if (bus_wr) begin
        if (wl_n < 256) begin
          wl_addr[wl_n] <= {7'd0, bus_addr};
          wl_data[wl_n] <= bus_wdata;
        end
        wl_n     <= wl_n + 1;
        bsy_left <= cfg_bsy;
      end else if (bus_rd && bus_addr && bsy_left > 0) begin
        bsy_left <= bsy_left - 1;
      end
      if (bus_rd && !bus_addr && ob_rd < ob_wr) ob_rd <= ob_rd + 1;
    end
  end

  // ---------------- sequencer reference model ----------------
  // phases: 0 idle, 1 poll, 2 write, 3 drain status, 4 drain data
  // items: kind*256+val, kind 0 command reg, 1 data reg, 2 drain
  int m_ph, m_cnt;
  int m_q[$];
  bit e_done, e_err;

  task automatic m_next();
    if (m_q.size() == 0) begin
      m_ph = 0;
      e_done = 1'b1;
    end else if (m_q[0] / 256 == 2) m_ph = 3;
    else m_ph = 1;
  endtask

  task automatic m_abort();
    m_q.delete();
    m_ph = 0;
    e_done = 1'b1;
    e_err = 1'b1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; e_done = 1'b0; e_err = 1'b0;
      m_q.delete();
    end else begin
      e_done = 1'b0;
      case (m_ph)
        0: if (req_valid) begin
          m_q.delete();
          case (req_op)
            2'd0: begin
              m_q.push_back(16'h060); m_q.push_back(16'h130); m_q.push_back(16'h200);
              m_q.push_back(16'h060); m_q.push_back(16'h143);
            end
            2'd1: begin m_q.push_back(16'h060); m_q.push_back(16'h140); end
            2'd2: m_q.push_back(256 + int'(req_byte));
            default: begin m_q.push_back(16'h0D4); m_q.push_back(256 + int'(req_byte)); end
          endcase
          m_cnt = 0;
          m_next();
        end
        1: if (stat[1]) begin
          m_cnt++;
          if (m_cnt == LIMIT) m_abort();
        end else m_ph = 2;
        2: begin
          void'(m_q.pop_front());
          m_cnt = 0;
          m_next();
        end
        3: if (stat[0]) m_ph = 4;
           else begin void'(m_q.pop_front()); m_cnt = 0; m_next(); end
        default: begin
          m_cnt++;
          if (m_cnt == LIMIT) m_abort(); else m_ph = 3;
        end
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  bit prev_poll_ok = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      automatic int kind = (m_q.size() > 0) ? m_q[0] / 256 : 3;
      automatic int val  = (m_q.size() > 0) ? m_q[0] % 256 : 0;
      automatic bit x_rd = (m_ph == 1) || (m_ph == 3) || (m_ph == 4);
      automatic bit x_wr = (m_ph == 2);
      automatic bit x_ad = (m_ph == 1) || (m_ph == 3) || (m_ph == 2 && kind == 0);
      chk("R13 strobes", {bus_rd, bus_wr, bus_addr}, {x_rd, x_wr, x_ad});
      if (x_wr) chk("R13 wdata", bus_wdata, val);
      chk("R9 busy", busy, m_ph != 0);
      chk("R2 ready", req_ready, m_ph == 0);
      chk("R9 done", done, e_done);
      chk("R10 tmo_err", tmo_err, e_err);
      if (bus_wr) chk("R3 poll before write", prev_poll_ok, 1);
      prev_poll_ok = bus_rd && bus_addr && !bus_rdata[1];
    end else prev_poll_ok = 1'b0;
  end

  // ---------------- directed stimulus ----------------
  int base;

  task automatic do_reset();
    rst_n = 1'b0; stuck = 1'b0; cfg_bsy = 0; ob_wr = 0; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [7:0] b, input string tag);
    @(negedge clk);
    base = wl_n;
    req_valid = 1'b1; req_op = op; req_byte = b;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
    chk({tag, " done seen"}, done, 1);
    @(negedge clk);
    chk("R9 done single cycle", done, 0);
  endtask

  task automatic chk_wr(input int idx, input int addr, input int data, input string tag);
    chk(tag, int'(wl_addr[base+idx]) * 256 + int'(wl_data[base+idx]), addr * 256 + data);
  endtask

  task automatic fill_ob(input int n);
    for (int i = 0; i < n; i++) ob_mem[i] = 8'(8'h30 + i);
    ob_wr = n;
  endtask

  initial begin
    do_reset();
    // R1
    chk("R1 busy", busy, 0);
    chk("R1 ready", req_ready, 1);
    chk("R1 done", done, 0);
    chk("R1 tmo_err", tmo_err, 0);
    chk("R1 strobes", {bus_rd, bus_wr}, 0);

    // R4 / R5 bring-up with stale bytes
    cfg_bsy = 2; fill_ob(3);
    run_op(2'd0, 8'h00, "R4");
    chk("R4 write count", wl_n - base, 4);
    chk_wr(0, 1, 8'h60, "R4 w0");
    chk_wr(1, 0, 8'h30, "R4 w1");
    chk_wr(2, 1, 8'h60, "R4 w2");
    chk_wr(3, 0, 8'h43, "R4 w3");
    chk("R5 drained", ob_rd, 3);

    // R5 bring-up with nothing stale
    cfg_bsy = 0;
    run_op(2'd0, 8'h00, "R5");
    chk("R5 empty drain writes", wl_n - base, 4);

    // R6 / R12 shut-down
    cfg_bsy = 1;
    run_op(2'd1, 8'h00, "R6");
    chk("R6 write count", wl_n - base, 2);
    chk_wr(0, 1, 8'h60, "R6 w0");
    chk_wr(1, 0, 8'h40, "R12 op1 value");

    // R7 keyboard byte
    cfg_bsy = 3;
    run_op(2'd2, 8'hA5, "R7");
    chk("R7 write count", wl_n - base, 1);
    chk_wr(0, 0, 8'hA5, "R7 w0");

    // R8 pointing-device byte
    cfg_bsy = 2;
    run_op(2'd3, 8'h3C, "R8");
    chk("R8 write count", wl_n - base, 2);
    chk_wr(0, 1, 8'hD4, "R8 w0");
    chk_wr(1, 0, 8'h3C, "R8 w1");

    // R2 request offered while busy is not taken
    @(negedge clk);
    base = wl_n;
    req_valid = 1'b1; req_op = 2'd3; req_byte = 8'h11;
    @(negedge clk);
    req_op = 2'd2; req_byte = 8'h77;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
    @(negedge clk);
    chk("R2 write count", wl_n - base, 2);
    chk_wr(1, 0, 8'h11, "R2 held byte ignored");

    // R10 poll timeout and stickiness
    do_reset();
    stuck = 1'b1;
    run_op(2'd2, 8'h55, "R10");
    chk("R10 no write", wl_n - base, 0);
    chk("R10 flag", tmo_err, 1);
    stuck = 1'b0;
    run_op(2'd1, 8'h00, "R10 later");
    chk("R10 later writes", wl_n - base, 2);
    chk("R10 sticky", tmo_err, 1);

    // R11 drain timeout
    do_reset();
    fill_ob(20);
    run_op(2'd0, 8'h00, "R11");
    chk("R11 flag", tmo_err, 1);
    chk("R11 writes", wl_n - base, 2);
    chk("R11 data reads", ob_rd, LIMIT);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule